// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a two-address configuration port on a byte-wide I/O bus. It has one address bit, a write strobe and a read strobe. Address 0 has two jobs. It is the index register, and it is also where the unlock and lock keys are written. Address 1 is the data window onto whichever register the index names.

Configuration space is closed after reset. It opens only when the entry key is written to address 0 on two index writes in a row. It closes again when the exit key is written there. A static select input swaps in a second key pair, for use in a companion-device variant.

Once the space is open, a logical-device-number register picks which device bank the later indices reach. Each bank holds an activate bit and a small register file. A read-only identification byte is also visible. The activate bits of all devices go out on a vector. The register file of one chosen device (the watchdog bank, device 8 by default) goes out as a flat vector for that device to use.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked, the index is 0x00, the logical device is 0, every activate bit is 0 and every bank register is 0x00.
- R2: Two back-to-back index writes (address 0) of the entry key open the space. The key is 0x87, or 0x88 when `alt_key_sel` is 1. The second key write is not stored as the index.
- R3: While locked, an index write of any byte other than the entry key, placed between the two key writes, restarts the unlock sequence. Data-port writes neither advance nor restart it.
- R4: While locked, data-port writes have no effect, and reads of either address return 0xFF.
- R5: While open, an index write of the exit key locks the space again. The exit key is 0xAA, or 0xBB when `alt_key_sel` is 1. Any other index write loads the index, and a read of address 0 returns the index.
- R6: With `alt_key_sel` at 1, 0x87 does not open the space, and 0xAA is an ordinary index value.
- R7: Index 0x07 holds the logical device number. Writes keep the low 4 bits, and reads return them with the upper bits 0.
- R8: Index 0x20 reads the constant identification byte (default 0x5C). Writes to it have no effect.
- R9: Index 0x30 bit 0 is the activate bit of the selected device, and the other bits read 0. Bit d of `dev_active` is device d's activate bit.
- R10: Indices 0xF0 to 0xF7 are eight read/write byte registers per device. A write reaches only the selected device.
- R11: `tap_regs` carries device 8's registers, with register 0xF0+k on bits [8k+7:8k].
- R12: Any other index reads 0x00, and writes to it have no effect.
- R13: `bus_rdata` is combinational. It is valid while `bus_rd` is 1 and is 0x00 while `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_key_sel | input | 1 | Static select of the second key pair |
| bus_addr | input | 1 | 0 = index/key port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data |
| dev_active | output | 16 | Activate bit of each logical device |
| tap_regs | output | 64 | Register file of the tapped device |

## Verification
A wrong key state shows up at once on any read, because a port that is locked when it should be open returns 0xFF instead of the index. It also shows up on outputs: a data write that lands when it should not changes `dev_active` or `tap_regs` at the next clock edge. A wrong logical-device number or index does not show up right away. It appears at the next data access, as a readback from the wrong bank, or as a change on the activate bit of the wrong device. So every write is compared against a bench model, and the model is read back through the bus.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_CHIP  = 8'h20;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [7:0] IDX_BANK0 = 8'hF0;

  function automatic logic [7:0] entry_key(input logic alt);
    return alt ? 8'h88 : 8'h87;
  endfunction

  function automatic logic [7:0] exit_key(input logic alt);
    return alt ? 8'hBB : 8'hAA;
  endfunction

  // true when idx falls in the per-device register window
  function automatic logic in_bank(input logic [7:0] idx, input int nreg);
    logic [7:0] off;
    off = idx - IDX_BANK0;
    return (idx >= IDX_BANK0) && (int'(off) < nreg);
  endfunction

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt_key,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output key_state_e state,
  output logic       open,
  output logic [7:0] idx_q,
  output logic       ev_unlock,
  output logic       ev_lock
);

  key_state_e state_d;
  logic [7:0] ent;
  logic [7:0] ex;
  logic       idx_load;

  assign ent = entry_key(alt_key);
  assign ex  = exit_key(alt_key);

  assign ev_unlock = (state == KS_HALF) && idx_wr && (wdata == ent);
  assign ev_lock   = (state == KS_OPEN) && idx_wr && (wdata == ex);
  assign idx_load  = (state == KS_OPEN) && idx_wr && !ev_lock;
  assign open      = (state == KS_OPEN);

  always_comb begin
    state_d = state;
    case (state)
      KS_LOCKED: if (idx_wr && wdata == ent) state_d = KS_HALF;
      KS_HALF:   if (idx_wr) state_d = (wdata == ent) ? KS_OPEN : KS_LOCKED;
      KS_OPEN:   if (ev_lock) state_d = KS_LOCKED;
      default:   state_d = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= KS_LOCKED;
      idx_q <= 8'h00;
    end else begin
      state <= state_d;
      if (idx_load) idx_q <= wdata;
    end
  end

endmodule

// File: rtl/cfg_dev_banks.sv
module cfg_dev_banks
  import cfg_port_pkg::*;
#(
  parameter int LDN_W   = 4,
  parameter int NREG    = 8,
  parameter int TAP_DEV = 8,
  localparam int NDEV   = 1 << LDN_W,
  localparam int SLOT_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  input  logic [LDN_W-1:0] ldn,
  output logic [NDEV-1:0]  act_q,
  output logic             rd_act,
  output logic [7:0]       rd_bank,
  output logic [NREG*8-1:0] tap_flat
);

  logic [7:0]        regs_q [NDEV][NREG];
  logic              bank_hit;
  logic [SLOT_W-1:0] slot;

  assign bank_hit = in_bank(idx, NREG);
  assign slot     = idx[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      for (int d = 0; d < NDEV; d++)
        for (int r = 0; r < NREG; r++)
          regs_q[d][r] <= 8'h00;
    end else if (wr_en) begin
      for (int d = 0; d < NDEV; d++) begin
        if (ldn == LDN_W'(d)) begin
          if (idx == IDX_ACT) act_q[d] <= wdata[0];
          for (int r = 0; r < NREG; r++)
            if (bank_hit && slot == SLOT_W'(r)) regs_q[d][r] <= wdata;
        end
      end
    end
  end

  assign rd_act  = act_q[ldn];
  assign rd_bank = bank_hit ? regs_q[ldn][slot] : 8'h00;

  for (genvar r = 0; r < NREG; r++) begin : g_tap
    assign tap_flat[r*8 +: 8] = regs_q[TAP_DEV][r];
  end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_port_pkg::*;
#(
  parameter int         LDN_W   = 4,
  parameter logic [7:0] CHIP_ID = 8'h5C
) (
  input  logic             rd,
  input  logic             addr,
  input  logic             open,
  input  logic [7:0]       idx,
  input  logic [LDN_W-1:0] ldn,
  input  logic             act_bit,
  input  logic [7:0]       bank_byte,
  output logic [7:0]       rdata
);

  always_comb begin
    if (!rd)        rdata = 8'h00;
    else if (!open) rdata = 8'hFF;
    else if (!addr) rdata = idx;
    else begin
      case (idx)
        IDX_LDN:  rdata = {{(8-LDN_W){1'b0}}, ldn};
        IDX_CHIP: rdata = CHIP_ID;
        IDX_ACT:  rdata = {7'b0, act_bit};
        default:  rdata = bank_byte;
      endcase
    end
  end

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int         LDN_W   = 4,
  parameter int         NREG    = 8,
  parameter int         TAP_DEV = 8,
  parameter logic [7:0] CHIP_ID = 8'h5C
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alt_key_sel,
  input  logic                    bus_addr,
  input  logic [7:0]              bus_wdata,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  output logic [7:0]              bus_rdata,
  output logic [(1<<LDN_W)-1:0]   dev_active,
  output logic [NREG*8-1:0]       tap_regs
);

  key_state_e       key_state;
  logic             cfg_open;
  logic [7:0]       idx_q;
  logic             ev_unlock;
  logic             ev_lock;
  logic             idx_wr;
  logic             data_wr;
  logic [LDN_W-1:0] ldn_q;
  logic             rd_act;
  logic [7:0]       rd_bank;

  assign idx_wr  = bus_wr && !bus_addr;
  assign data_wr = bus_wr && bus_addr && cfg_open;

  cfg_key_fsm u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .alt_key   (alt_key_sel),
    .idx_wr    (idx_wr),
    .wdata     (bus_wdata),
    .state     (key_state),
    .open      (cfg_open),
    .idx_q     (idx_q),
    .ev_unlock (ev_unlock),
    .ev_lock   (ev_lock)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                            ldn_q <= '0;
    else if (data_wr && idx_q == IDX_LDN)  ldn_q <= bus_wdata[LDN_W-1:0];
  end

  cfg_dev_banks #(.LDN_W(LDN_W), .NREG(NREG), .TAP_DEV(TAP_DEV)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (data_wr),
    .idx      (idx_q),
    .wdata    (bus_wdata),
    .ldn      (ldn_q),
    .act_q    (dev_active),
    .rd_act   (rd_act),
    .rd_bank  (rd_bank),
    .tap_flat (tap_regs)
  );

  cfg_read_mux #(.LDN_W(LDN_W), .CHIP_ID(CHIP_ID)) u_rmux (
    .rd        (bus_rd),
    .addr      (bus_addr),
    .open      (cfg_open),
    .idx       (idx_q),
    .ldn       (ldn_q),
    .act_bit   (rd_act),
    .bank_byte (rd_bank),
    .rdata     (bus_rdata)
  );

endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk
  import cfg_port_pkg::*;
#(
  parameter int         LDN_W   = 4,
  parameter int         NREG    = 8,
  parameter logic [7:0] CHIP_ID = 8'h5C
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  alt_key_sel,
  input logic                  bus_addr,
  input logic [7:0]            bus_wdata,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [7:0]            bus_rdata,
  input logic [(1<<LDN_W)-1:0] dev_active,
  input logic [NREG*8-1:0]     tap_regs,
  input key_state_e            key_state,
  input logic                  cfg_open,
  input logic [7:0]            idx_q,
  input logic                  ev_unlock,
  input logic                  ev_lock,
  input logic                  data_wr
);

  assert_locked_read_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !cfg_open) |-> bus_rdata == 8'hFF);

  assert_open_after_key_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(ev_unlock));

  assert_exit_key_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock |=> !cfg_open);

  assert_bad_byte_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_state == KS_HALF && bus_wr && !bus_addr && bus_wdata != entry_key(alt_key_sel))
    |=> key_state == KS_LOCKED);

  assert_act_changes_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_active) |-> ($past(data_wr) && $past(idx_q) == IDX_ACT));

  assert_tap_changes_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_regs) |-> $past(data_wr));

  assert_chip_id_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && cfg_open && bus_addr && idx_q == IDX_CHIP) |-> bus_rdata == CHIP_ID);

  assert_idle_rdata_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 8'h00);

endmodule

bind keyed_cfg_port cfg_port_chk #(.LDN_W(LDN_W), .NREG(NREG), .CHIP_ID(CHIP_ID)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alt_key_sel (alt_key_sel),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .dev_active  (dev_active),
  .tap_regs    (tap_regs),
  .key_state   (key_state),
  .cfg_open    (cfg_open),
  .idx_q       (idx_q),
  .ev_unlock   (ev_unlock),
  .ev_lock     (ev_lock),
  .data_wr     (data_wr)
);

// File: tb/keyed_cfg_port_test.sv
`timescale 1ns/1ps
module keyed_cfg_port_test;

  localparam int         NDEV = 16;
  localparam int         NREG = 8;
  localparam int         TAP  = 8;
  localparam logic [7:0] CHIP = 8'h5C;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 alt_key_sel = 1'b0;
  logic                 bus_addr = 1'b0;
  logic [7:0]           bus_wdata = 8'h00;
  logic                 bus_wr = 1'b0;
  logic                 bus_rd = 1'b0;
  logic [7:0]           bus_rdata;
  logic [NDEV-1:0]      dev_active;
  logic [NREG*8-1:0]    tap_regs;

  always #2.5 clk = ~clk;

  keyed_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .alt_key_sel(alt_key_sel), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dev_active(dev_active), .tap_regs(tap_regs)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model
  bit              m_open, m_half, m_alt;
  logic [7:0]      m_idx;
  logic [3:0]      m_ldn;
  logic [NDEV-1:0] m_act;
  logic [7:0]      m_bank [NDEV][NREG];

  function automatic logic [7:0] k_ent(); return m_alt ? 8'h88 : 8'h87; endfunction
  function automatic logic [7:0] k_ex();  return m_alt ? 8'hBB : 8'hAA; endfunction

  function automatic logic [7:0] model_read(input logic a);
    if (!m_open) return 8'hFF;
    if (!a) return m_idx;
    if (m_idx == 8'h07) return {4'h0, m_ldn};
    if (m_idx == 8'h20) return CHIP;
    if (m_idx == 8'h30) return {7'b0, m_act[m_ldn]};
    if (m_idx >= 8'hF0 && m_idx <= 8'hF7) return m_bank[m_ldn][m_idx[2:0]];
    return 8'h00;
  endfunction

  function automatic logic [NREG*8-1:0] model_tap();
    logic [NREG*8-1:0] v;
    for (int r = 0; r < NREG; r++) v[r*8 +: 8] = m_bank[TAP][r];
    return v;
  endfunction

  task automatic model_write(input logic a, input logic [7:0] d);
    if (!a) begin
      if (!m_open) begin
        if (m_half) begin m_open = (d == k_ent()); m_half = 0; end
        else m_half = (d == k_ent());
      end else if (d == k_ex()) m_open = 0;
      else m_idx = d;
    end else if (m_open) begin
      if (m_idx == 8'h07) m_ldn = d[3:0];
      else if (m_idx == 8'h30) m_act[m_ldn] = d[0];
      else if (m_idx >= 8'hF0 && m_idx <= 8'hF7) m_bank[m_ldn][m_idx[2:0]] = d;
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic alt);
    @(negedge clk);
    rst_n = 0; alt_key_sel = alt; m_alt = alt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_open = 0; m_half = 0; m_idx = 8'h00; m_ldn = 4'h0; m_act = '0;
    for (int d = 0; d < NDEV; d++) for (int r = 0; r < NREG; r++) m_bank[d][r] = 8'h00;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    model_write(a, d);
  endtask

  task automatic rd(input logic a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1;
    chk(tag, 64'(bus_rdata), 64'(model_read(a)));
    bus_rd = 0;
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " dev_active"}, 64'(dev_active), 64'(m_act));
    chk({tag, " tap_regs"}, tap_regs, model_tap());
  endtask

  task automatic unlock();
    wr(0, k_ent()); wr(0, k_ent());
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] d);
    wr(0, i); wr(1, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset(0);
    // R13: idle read data
    #1; chk("R13 idle rdata", 64'(bus_rdata), 64'h0);
    // R1 / R4: reset state locked
    rd(1, "R1 locked data read");
    rd(0, "R4 locked index read");
    chk_outs("R1 reset outputs");
    // R4: locked data write ignored
    wr(1, 8'h55);
    rd(1, "R4 after locked data write");
    // R2: unlock, second key not stored as index (index still 0 per R1)
    unlock();
    rd(0, "R2 index after unlock");
    chk(
      "R2 open index zero", 64'(m_idx), 64'h0);
    wr(0, 8'h07);
    rd(1, "R1 ldn zero after reset");
    // R7: ldn low bits
    wr(1, 8'h3B);
    rd(1, "R7 ldn readback");
    // R8: chip id read-only
    set_reg(8'h20, 8'h00);
    rd(1, "R8 chip id");
    // R9: activate bit on device 8
    set_reg(8'h07, 8'h08);
    set_reg(8'h30, 8'hFF);
    rd(1, "R9 activate bit");
    chk_outs("R9 dev_active");
    // R10 / R11: bank isolation
    set_reg(8'hF0, 8'hA1);
    set_reg(8'hF7, 8'h7E);
    chk_outs("R11 tap after writes");
    set_reg(8'h07, 8'h03);
    set_reg(8'hF0, 8'h33);
    rd(1, "R10 device 3 slot 0");
    set_reg(8'h07, 8'h08);
    wr(0, 8'hF0); rd(1, "R10 device 8 slot 0 kept");
    chk_outs("R10 outputs isolated");
    // R12: unmapped index
    set_reg(8'hF8, 8'h10);
    rd(1, "R12 unmapped read");
    chk_outs("R12 no effect");
    // R5: lock with exit key
    wr(0, 8'hAA);
    rd(0, "R5 locked after exit");
    // R3: interrupted sequence
    wr(0, 8'h87); wr(1, 8'h00); wr(0, 8'h12); wr(0, 8'h87);
    rd(0, "R3 still locked");
    wr(0, 8'h87);
    rd(0, "R3 open after fresh pair");
    chk(
      "R3 model open", 64'(m_open), 64'h1);

    // R6: alternate keys
    do_reset(1);
    wr(0, 8'h87); wr(0, 8'h87);
    rd(0, "R6 normal key rejected");
    unlock();
    wr(0, 8'hAA);
    rd(0, "R6 AA is plain index");
    wr(0, 8'hBB);
    rd(1, "R6 BB locks");

    // random phase, mixed keys
    do_reset(0);
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (n == 1500) do_reset(1);
      if (op <= 2) begin
        logic [7:0] v;
        case ($urandom_range(0, 7))
          0, 1: v = k_ent();
          2:    v = k_ex();
          3:    v = 8'h07;
          4:    v = 8'h30;
          5:    v = 8'hF0 + 8'($urandom_range(0, 9));
          6:    v = 8'h20;
          default: v = 8'($urandom_range(0, 255));
        endcase
        wr(0, v);
      end else if (op <= 5) begin
        wr(1, 8'($urandom_range(0, 255)));
      end else if (op <= 8) begin
        rd(1'($urandom_range(0, 1)), "R10 random read");
      end else begin
        chk_outs("R11 random outputs");
      end
    end
    chk_outs("R9 final outputs");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule